// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block turns a 32-bit virtual address into a 20-bit physical address. It keeps a small, fully associative store of recent page mappings. Pages are 32 KiB, so the low 15 address bits are the page offset and pass through unchanged. The upper 17 bits are the virtual page number, and the stored translation supplies a 5-bit physical page number. Every request, whether a read or a write, produces exactly one response one cycle later: a hit carrying the physical address, a miss that hands the page number to an external page walker, or a protection fault when the stored permissions forbid the access.

The walker answers with a fill, which installs the mapping. A fill goes first to an empty slot. When every slot is valid, it replaces the least recently used slot. A flush, raised on a context switch, invalidates every slot at once.

Top module: `tlbx_top`

## Requirements
- R1: After reset no slot holds a valid mapping. Every response output is 0, and the first request to any page answers with a miss.
- R2: A request sampled at a clock edge gives a one-cycle `rsp_valid` pulse after that edge with exactly one of `rsp_hit`, `rsp_miss`, `rsp_fault` set. With no request, all four outputs stay 0.
- R3: On a hit, `rsp_paddr` is the stored 5-bit physical page number in bits 19:15, followed by the request's offset bits 14:0 in bits 14:0.
- R4: On a miss, `walk_vpn` carries the request's virtual address bits 31:15 and `rsp_paddr` is 0.
- R5: A fill installs the mapping of `fill_vpn` to `fill_ppn` with its permissions. A later request to that page hits.
- R6: A read needs the read permission of the matching slot and a write needs its write permission. A denied access answers with a fault and `rsp_paddr` of 0, and it does not count as a use for replacement.
- R7: A fill takes an empty slot while one exists. Up to four distinct pages can therefore be held at once without evicting any of them.
- R8: When all four slots are valid, a fill of a new page replaces the slot least recently touched by a permitted hit or a fill.
- R9: A flush invalidates every slot. Requests after it miss until the pages are filled again.
- R10: A flush and a fill in the same cycle leave no valid slot. The filled page misses afterwards.
- R11: A fill for a page already held overwrites that slot in place and makes it most recent. No other slot is evicted.
- R12: A request in the same cycle as a fill or a flush is looked up against the contents held before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request this cycle |
| req_vaddr | input | 32 | Virtual address of the request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| fill_valid | input | 1 | Walker returns a mapping this cycle |
| fill_vpn | input | 17 | Virtual page number being installed |
| fill_ppn | input | 5 | Physical page number being installed |
| fill_rd | input | 1 | Read permission of the installed page |
| fill_wr | input | 1 | Write permission of the installed page |
| flush | input | 1 | Invalidate all slots |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | Permitted translation |
| rsp_miss | output | 1 | No mapping held; walk requested |
| rsp_fault | output | 1 | Mapping held but access denied |
| rsp_paddr | output | 20 | Physical address on hit, else 0 |
| walk_vpn | output | 17 | Page number to walk on miss, else 0 |

## Verification
The hardest case to reach from the ports is a replacement decision that depends on the full history of uses. This matters most when a faulting access touches the slot that is currently oldest, because a correct block must then still evict that slot. The stimulus fills all four slots, reads them in a chosen order, and then issues a denied access to the oldest slot before the next fill. Afterwards it probes every page, so an eviction of the wrong slot shows up as a miss where a hit was expected. The bench's own model tracks last-use times instead of ages, so it predicts each eviction independently of the design.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
  localparam int VA_W  = 32;
  localparam int PA_W  = 20;
  localparam int OFF_W = 15;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;

  typedef struct packed {
    logic             vld;
    logic [VPN_W-1:0] tag;
    logic [PPN_W-1:0] ppn;
    logic             rd;
    logic             wr;
  } tlbx_entry_t;
endpackage

// File: rtl/tlbx_match.sv
module tlbx_match
  import tlbx_pkg::*;
#(
  parameter int N = 4
) (
  input  tlbx_entry_t [N-1:0] ents,
  input  logic [VPN_W-1:0]    vpn,
  output logic [N-1:0]        hit_vec
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_vec[i] = ents[i].vld && (ents[i].tag == vpn);
  end
endmodule

// File: rtl/tlbx_age.sv
module tlbx_age #(
  parameter  int N  = 4,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch_en,
  input  logic [IW-1:0] touch_idx,
  input  logic [N-1:0]  valid_vec,
  output logic [IW-1:0] victim_idx
);
  logic [N-1:0][IW-1:0] age_q, age_d;
  logic                 found;

  // ages form a permutation: 0 = youngest, N-1 = oldest
  always_comb begin
    age_d = age_q;
    for (int i = 0; i < N; i++) begin
      if (IW'(i) == touch_idx) age_d[i] = '0;
      else if (age_q[i] < age_q[touch_idx]) age_d[i] = age_q[i] + 1'b1;
    end
  end

  always_comb begin
    victim_idx = '0;
    found      = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!valid_vec[i] && !found) begin
        victim_idx = IW'(i);
        found      = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < N; i++) begin
        if (age_q[i] == IW'(N-1)) victim_idx = IW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
    end else if (touch_en) begin
      age_q <= age_d;
    end
  end
endmodule

// File: rtl/tlbx_top.sv
module tlbx_top
  import tlbx_pkg::*;
#(
  parameter  int ENTRIES = 4,
  localparam int IW      = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_rd,
  input  logic             fill_wr,
  input  logic             flush,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [VPN_W-1:0] walk_vpn
);
  tlbx_entry_t [ENTRIES-1:0] ents_q, ents_d;
  logic [ENTRIES-1:0] req_hv, fill_hv, vld_vec;
  logic [VPN_W-1:0]   req_vpn;
  tlbx_entry_t        sel_e;
  logic               perm_ok, lk_hit, grant, deny, lk_miss;
  logic               fill_take, touch_en, ents_we;
  logic [IW-1:0]      victim_idx, fill_slot, touch_idx;

  logic               v_q, h_q, m_q, f_q;
  logic [PA_W-1:0]    pa_q, pa_d;
  logic [VPN_W-1:0]   wv_q, wv_d;

  function automatic logic [IW-1:0] oh2idx(input logic [ENTRIES-1:0] oh);
    logic [IW-1:0] r;
    r = '0;
    for (int i = 0; i < ENTRIES; i++) if (oh[i]) r = r | IW'(i);
    return r;
  endfunction

  assign req_vpn = req_vaddr[VA_W-1:OFF_W];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_vld
    assign vld_vec[i] = ents_q[i].vld;
  end

  tlbx_match #(.N(ENTRIES)) u_req_match (
    .ents(ents_q), .vpn(req_vpn), .hit_vec(req_hv)
  );

  tlbx_match #(.N(ENTRIES)) u_fill_match (
    .ents(ents_q), .vpn(fill_vpn), .hit_vec(fill_hv)
  );

  tlbx_age #(.N(ENTRIES)) u_age (
    .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_idx(touch_idx),
    .valid_vec(vld_vec), .victim_idx(victim_idx)
  );

  // lookup against current contents
  always_comb begin
    sel_e = '0;
    for (int i = 0; i < ENTRIES; i++) if (req_hv[i]) sel_e = ents_q[i];
  end

  assign perm_ok = req_write ? sel_e.wr : sel_e.rd;
  assign lk_hit  = req_valid & (|req_hv);
  assign grant   = lk_hit & perm_ok;
  assign deny    = lk_hit & ~perm_ok;
  assign lk_miss = req_valid & ~(|req_hv);

  // fill placement and replacement bookkeeping
  assign fill_slot = (|fill_hv) ? oh2idx(fill_hv) : victim_idx;
  assign fill_take = fill_valid & ~flush;
  assign touch_en  = fill_take | grant;
  assign touch_idx = fill_take ? fill_slot : oh2idx(req_hv);
  assign ents_we   = flush | fill_valid;

  always_comb begin
    ents_d = ents_q;
    if (flush) begin
      for (int i = 0; i < ENTRIES; i++) ents_d[i].vld = 1'b0;
    end else if (fill_valid) begin
      ents_d[fill_slot].vld = 1'b1;
      ents_d[fill_slot].tag = fill_vpn;
      ents_d[fill_slot].ppn = fill_ppn;
      ents_d[fill_slot].rd  = fill_rd;
      ents_d[fill_slot].wr  = fill_wr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ents_q <= '0;
    else if (ents_we) ents_q <= ents_d;
  end

  // response next state
  assign pa_d = grant ? {sel_e.ppn, req_vaddr[OFF_W-1:0]} : '0;
  assign wv_d = lk_miss ? req_vpn : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q  <= 1'b0;
      h_q  <= 1'b0;
      m_q  <= 1'b0;
      f_q  <= 1'b0;
      pa_q <= '0;
      wv_q <= '0;
    end else begin
      v_q  <= req_valid;
      h_q  <= grant;
      m_q  <= lk_miss;
      f_q  <= deny;
      pa_q <= pa_d;
      wv_q <= wv_d;
    end
  end

  assign rsp_valid = v_q;
  assign rsp_hit   = h_q;
  assign rsp_miss  = m_q;
  assign rsp_fault = f_q;
  assign rsp_paddr = pa_q;
  assign walk_vpn  = wv_q;
endmodule

// File: rtl/tlbx_chk.sv
module tlbx_chk
  import tlbx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [VA_W-1:0]  req_vaddr,
  input logic             req_write,
  input logic             fill_valid,
  input logic [VPN_W-1:0] fill_vpn,
  input logic [PPN_W-1:0] fill_ppn,
  input logic             fill_rd,
  input logic             fill_wr,
  input logic             flush,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_miss,
  input logic             rsp_fault,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic [VPN_W-1:0] walk_vpn
);
  assert_single_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);

  assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault));

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_offset_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_hit -> rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));

  assert_walk_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_miss -> walk_vpn == $past(req_vaddr[VA_W-1:OFF_W])));

  assert_fault_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_paddr == '0);

  assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush ##1 req_valid |=> rsp_miss);
endmodule

bind tlbx_top tlbx_chk u_chk (.*);

// File: tb/tlbx_top_test.sv
module tlbx_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        fill_valid = 1'b0;
  logic [16:0] fill_vpn = '0;
  logic [4:0]  fill_ppn = '0;
  logic        fill_rd = 1'b0;
  logic        fill_wr = 1'b0;
  logic        flush = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
  logic [19:0] rsp_paddr;
  logic [16:0] walk_vpn;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlbx_top uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .fill_rd(fill_rd), .fill_wr(fill_wr), .flush(flush),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .walk_vpn(walk_vpn)
  );

  typedef struct {
    bit          h;
    bit          m;
    bit          f;
    logic [19:0] pa;
    logic [16:0] wv;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t got_e;

  // reference model: last-use timestamps
  bit          mv[4];
  logic [16:0] mt[4];
  logic [4:0]  mp[4];
  bit          mr[4];
  bit          mw[4];
  int          mts[4];
  int          now = 0;

  function automatic logic [31:0] va(input logic [16:0] v, input logic [14:0] o);
    return {v, o};
  endfunction

  task automatic step(input bit rq, input logic [31:0] a, input bit wr,
                      input bit fl, input logic [16:0] fv, input logic [4:0] fp,
                      input bit fr, input bit fw, input bit fsh, input string tag);
    exp_t e;
    int   k;
    if (rq) begin
      k = -1;
      for (int i = 0; i < 4; i++) if (mv[i] && mt[i] == a[31:15]) k = i;
      e.h = 0; e.m = 0; e.f = 0; e.pa = '0; e.wv = '0; e.tag = tag;
      if (k < 0) begin
        e.m = 1; e.wv = a[31:15];
      end else if (wr ? mw[k] : mr[k]) begin
        e.h = 1; e.pa = {mp[k], a[14:0]};
        now++; mts[k] = now;
      end else begin
        e.f = 1;
      end
      q.push_back(e);
    end
    if (fsh) begin
      for (int i = 0; i < 4; i++) mv[i] = 0;
    end else if (fl) begin
      k = -1;
      for (int i = 0; i < 4; i++) if (mv[i] && mt[i] == fv) k = i;
      if (k < 0) for (int i = 3; i >= 0; i--) if (!mv[i]) k = i;
      if (k < 0) begin
        k = 0;
        for (int i = 1; i < 4; i++) if (mts[i] < mts[k]) k = i;
      end
      mv[k] = 1; mt[k] = fv; mp[k] = fp; mr[k] = fr; mw[k] = fw;
      now++; mts[k] = now;
    end
    req_valid = rq; req_vaddr = a; req_write = wr;
    fill_valid = fl; fill_vpn = fv; fill_ppn = fp; fill_rd = fr; fill_wr = fw;
    flush = fsh;
    @(negedge clk);
    req_valid = 0; fill_valid = 0; flush = 0;
  endtask

  task automatic rd(input logic [31:0] a, input string tag);
    step(1, a, 0, 0, '0, '0, 0, 0, 0, tag);
  endtask

  task automatic wrq(input logic [31:0] a, input string tag);
    step(1, a, 1, 0, '0, '0, 0, 0, 0, tag);
  endtask

  task automatic fill(input logic [16:0] v, input logic [4:0] p, input bit r,
                      input bit w, input string tag);
    step(0, '0, 0, 1, v, p, r, w, 0, tag);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid && !done) begin
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R2: unexpected response got valid=1 expected valid=0");
      end else begin
        got_e = q.pop_front();
        if (rsp_hit !== got_e.h || rsp_miss !== got_e.m || rsp_fault !== got_e.f ||
            rsp_paddr !== got_e.pa || walk_vpn !== got_e.wv) begin
          fails++;
          $display("FAIL %s: got h=%0b m=%0b f=%0b pa=%h wv=%h expected h=%0b m=%0b f=%0b pa=%h wv=%h",
                   got_e.tag, rsp_hit, rsp_miss, rsp_fault, rsp_paddr, walk_vpn,
                   got_e.h, got_e.m, got_e.f, got_e.pa, got_e.wv);
        end
      end
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    fails++;
    $display("FAIL R2: watchdog expired got running expected finished");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      mv[i] = 0; mt[i] = '0; mp[i] = '0; mr[i] = 0; mw[i] = 0; mts[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    checks++;
    if (rsp_valid !== 0 || rsp_hit !== 0 || rsp_miss !== 0 || rsp_fault !== 0 ||
        rsp_paddr !== '0 || walk_vpn !== '0) begin
      fails++;
      $display("FAIL R1: reset outputs got v=%0b h=%0b m=%0b f=%0b expected all 0",
               rsp_valid, rsp_hit, rsp_miss, rsp_fault);
    end

    rd(va(17'h00003, 15'h0123), "R1");
    rd(va(17'h1ffff, 15'h0000), "R4");
    fill(17'h00003, 5'd5, 1, 0, "R5");
    rd(va(17'h00003, 15'h0123), "R5");
    rd(va(17'h00003, 15'h7fff), "R3");
    wrq(va(17'h00003, 15'h7fff), "R6");

    // fill remaining empty slots
    fill(17'h1ffff, 5'd31, 1, 1, "R7");
    fill(17'h00000, 5'd0, 1, 1, "R7");
    fill(17'h0abcd, 5'd12, 0, 1, "R7");
    rd(va(17'h00003, 15'h0001), "R7");
    rd(va(17'h1ffff, 15'h7ffe), "R7");
    rd(va(17'h00000, 15'h4000), "R3");
    wrq(va(17'h0abcd, 15'h2aaa), "R7");
    rd(va(17'h0abcd, 15'h2aaa), "R6");

    // LRU eviction: 0x00003 is oldest now
    fill(17'h00777, 5'd7, 1, 1, "R8");
    rd(va(17'h00003, 15'h0010), "R8");
    rd(va(17'h00777, 15'h0010), "R8");

    // fault does not refresh: make 0x0abcd oldest then deny it
    rd(va(17'h1ffff, 15'h0020), "R8");
    rd(va(17'h00000, 15'h0030), "R8");
    rd(va(17'h00777, 15'h0040), "R8");
    rd(va(17'h0abcd, 15'h0050), "R6");
    fill(17'h00888, 5'd8, 1, 1, "R6");
    wrq(va(17'h0abcd, 15'h0050), "R6");
    rd(va(17'h1ffff, 15'h0060), "R6");

    // refill of a held page overwrites in place
    fill(17'h00888, 5'd20, 1, 1, "R11");
    rd(va(17'h00888, 15'h1234), "R11");
    rd(va(17'h1ffff, 15'h0001), "R11");
    rd(va(17'h00000, 15'h0002), "R11");
    rd(va(17'h00777, 15'h0003), "R11");

    // same-cycle request and fill sees old contents
    step(1, va(17'h00055, 15'h0100), 0, 1, 17'h00055, 5'd21, 1, 0, 0, "R12");
    rd(va(17'h00055, 15'h0100), "R12");
    wrq(va(17'h00055, 15'h0100), "R6");

    // same-cycle request and flush sees old contents, then flush takes effect
    step(1, va(17'h00055, 15'h0200), 0, 0, '0, '0, 0, 0, 1, "R12");
    rd(va(17'h00055, 15'h0200), "R9");
    rd(va(17'h00888, 15'h0000), "R9");
    rd(va(17'h1ffff, 15'h0000), "R9");
    rd(va(17'h00000, 15'h0000), "R9");

    // flush wins over fill
    fill(17'h00100, 5'd1, 1, 1, "R10");
    step(0, '0, 0, 1, 17'h00200, 5'd2, 1, 1, 1, "R10");
    rd(va(17'h00200, 15'h0000), "R10");
    rd(va(17'h00100, 15'h0000), "R10");
    fill(17'h00200, 5'd2, 1, 1, "R5");
    rd(va(17'h00200, 15'h0abc), "R5");

    repeat (3) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R2: missing responses got %0d pending expected 0", q.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule